// File: doc/BRIEF.md
# Quad-SPI Streaming Read Bridge

This block lets a parallel master that can never be stalled use a serial NOR flash as a boot ROM. The master first strobes in a 24-bit start address. The bridge then deselects the flash, reselects it, and sends a quad-output read header. It then streams data continuously over four data lines into a small prefetch FIFO. Each later master read strobe takes the next 16-bit word from the FIFO, so the master never waits on a serial transaction.

The serial clock is a divided copy of the system clock, and the division ratio is a parameter. Chip select stays low for the whole burst, and the flash increments its own address. When the FIFO fills, the serial clock stops in its low phase, and chip select stays low so the stream can resume. The bus is split into output, output-enable and input vectors, and the pad buffers sit outside the block.

Top module: `qsb_top`

## Requirements
- R1: While reset is applied, `flash_cs_n` is 1, `flash_sck` is 0, `flash_io_oe` is 0, `rd_data` is 0 and `underrun` is 0.
- R2: After `addr_load`, chip select goes low and the bridge sends 32 bits on line 0 (`flash_io_oe` = 4'b0001), most significant bit first: first the `READ_CMD` byte (default 8'h6B), then the 24-bit address. Each bit changes after a falling edge of `flash_sck` and is taken by the flash on the next rising edge.
- R3: After `DUMMY_CYCLES` more clocks (default 8), all four lines are sampled on each rising edge. Four nibbles form one word, the first nibble in bits 15:12. With the flash sending the high nibble of each byte first, word j is {byte(A+2j), byte(A+2j+1)}.
- R4: Chip select stays low through the burst. Successive accepted reads return successive words, with no gap and no repeat.
- R5: While the FIFO (`FIFO_DEPTH` words, default 4) is full, `flash_sck` stays low and `flash_cs_n` stays low, and no word is lost.
- R6: `flash_sck` has a period of 2*`CLK_DIV` system clocks (default 2, so 40 ns at a 10 ns system clock).
- R7: A read strobe that finds the FIFO empty sets `underrun` and leaves `rd_data` at the last valid word. `underrun` stays set until the next `addr_load`.
- R8: `addr_load` raises chip select on the next cycle, flushes the FIFO, clears `underrun`, and restarts the header at the new address.
- R9: When `addr_load` and `rd_stb` come in the same cycle, the load wins and the read is ignored: `rd_data` is unchanged, `underrun` is not set, and the first word read afterwards is word 0 of the new address.
- R10: With `SAMPLE_DELAY` = 1, the lines are sampled one system clock after the rising edge of `flash_sck`, to allow for round-trip pad delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Start-address strobe, one cycle |
| addr_in | input | 24 | Start byte address |
| rd_stb | input | 1 | Master read strobe, one cycle |
| rd_data | output | 16 | Word returned by the latest read |
| underrun | output | 1 | Sticky: a read found the FIFO empty |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock, idles low |
| flash_io_out | output | 4 | Values driven onto the data lines |
| flash_io_oe | output | 4 | Per-line output enable |
| flash_io_in | input | 4 | Values sampled from the data lines |

## Verification
The FIFO can take a word from the flash and hand one to the master in the same cycle. It can also receive a flush from a new address strobe while a read strobe is present. The first case arises naturally: reads come every 20 cycles and a word arrives every 16 cycles, so pushes and pops land on the same edge again and again, and the scoreboard shows whether any word was dropped or repeated. The second case is provoked on purpose by raising the load and read strobes together on a full FIFO. The unchanged `rd_data`, the clear `underrun` flag and the first word read afterwards show that the load took priority.

// File: rtl/qsb_pkg.sv
// Shared types for the quad-SPI streaming bridge.
// Assumes 24-bit flash byte addressing and 16-bit master words.
package qsb_pkg;
    localparam int ADDR_W = 24;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,   // no burst yet, chip select high
        ST_GAP,    // chip select high between bursts
        ST_PRE,    // command, address and dummy clocks
        ST_DATA    // quad data streaming
    } seq_state_t;
endpackage

// File: rtl/qsb_sck_gen.sv
// Serial clock divider with gating.
// Produces a clock that idles low, with CLK_DIV system clocks per half period.
// Reports the edge where the clock rises and the edge where it falls.
// Assumes hold only ever stops the clock in its low phase.
module qsb_sck_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic sck,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick     = (cnt == CW'(CLK_DIV - 1));
    assign rise_evt = run && tick && !sck && !hold;
    assign fall_evt = run && tick && sck;

    // Count half periods and toggle the clock, pausing low while held.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck <= 1'b0;
            cnt <= '0;
        end else if (tick) begin
            if (sck || !hold) begin
                sck <= ~sck;
                cnt <= '0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_sck_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold && !sck) |=> !sck);
endmodule

// File: rtl/qsb_fifo.sv
// Prefetch FIFO holding words between the flash stream and the master.
// DEPTH must be a power of two. Flush takes priority over push and pop.
// Read data is the head entry, shown combinationally.
module qsb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rp];

    // Write the storage entry; it needs no reset.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);
endmodule

// File: rtl/qsb_seq.sv
// Flash-side sequencer.
// Sends the read command and address on line 0, counts the dummy clocks,
// then assembles four sampled nibbles into each 16-bit word.
// With SAMPLE_DELAY set, it samples one system clock after the rising edge.
// Assumes the serial clock generator reports its edge events one cycle wide.
module qsb_seq
    import qsb_pkg::*;
#(
    parameter logic [7:0] READ_CMD     = 8'h6B,
    parameter int         DUMMY_CYCLES = 8,
    parameter bit         SAMPLE_DELAY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              fifo_full,
    input  logic [3:0]        io_in,
    output logic              run,
    output logic              hold,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);
    localparam int HDR_BITS = 8 + ADDR_W;
    localparam int PRE_BITS = HDR_BITS + DUMMY_CYCLES;
    localparam int CNT_W    = $clog2(PRE_BITS + 1);

    seq_state_t          state;
    logic [1:0]          gap_cnt;
    logic [CNT_W-1:0]    pre_cnt;
    logic [HDR_BITS-1:0] shreg;
    logic [1:0]          nib_cnt;
    logic [11:0]         word_acc;
    logic                smp_evt;

    generate
        if (SAMPLE_DELAY) begin : g_late
            logic rise_q;
            // Delay the sample strobe by one system clock.
            always_ff @(posedge clk) begin
                if (!rst_n || start) rise_q <= 1'b0;
                else                 rise_q <= rise_evt && (state == ST_DATA);
            end
            assign smp_evt = rise_q && (state == ST_DATA);
        end else begin : g_edge
            assign smp_evt = rise_evt && (state == ST_DATA);
        end
    endgenerate

    assign run       = (state == ST_PRE) || (state == ST_DATA);
    assign hold      = (state == ST_DATA) && fifo_full;
    assign io_out    = {3'b000, shreg[HDR_BITS-1]};
    assign io_oe     = ((state == ST_PRE) && (pre_cnt < CNT_W'(HDR_BITS))) ? 4'b0001 : 4'b0000;
    assign push      = smp_evt && (nib_cnt == 2'd3) && !start;
    assign push_data = {word_acc, io_in};

    // Step through gap, header and dummy phases, then gather nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            gap_cnt  <= '0;
            pre_cnt  <= '0;
            shreg    <= '0;
            nib_cnt  <= '0;
            word_acc <= '0;
        end else if (start) begin
            state   <= ST_GAP;
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            shreg   <= {READ_CMD, start_addr};
            nib_cnt <= '0;
        end else begin
            case (state)
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == 2'd3) begin
                        state   <= ST_PRE;
                        cs_n    <= 1'b0;
                        pre_cnt <= '0;
                    end
                end
                ST_PRE: begin
                    if (fall_evt) shreg <= shreg << 1;
                    if (rise_evt) begin
                        pre_cnt <= pre_cnt + 1'b1;
                        if (pre_cnt == CNT_W'(PRE_BITS - 1)) state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (smp_evt) begin
                        word_acc <= {word_acc[7:0], io_in};
                        nib_cnt  <= nib_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/qsb_top.sv
// Quad-SPI streaming read bridge, top level.
// Joins the sequencer, the clock divider and the prefetch FIFO.
// Serves master reads from the FIFO. Assumes addr_load and rd_stb are
// single-cycle strobes, synchronous to clk.
module qsb_top #(
    parameter int         CLK_DIV      = 2,
    parameter int         DUMMY_CYCLES = 8,
    parameter int         FIFO_DEPTH   = 4,
    parameter bit         SAMPLE_DELAY = 1'b0,
    parameter logic [7:0] READ_CMD     = 8'h6B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_load,
    input  logic [23:0] addr_in,
    input  logic        rd_stb,
    output logic [15:0] rd_data,
    output logic        underrun,
    output logic        flash_cs_n,
    output logic        flash_sck,
    output logic [3:0]  flash_io_out,
    output logic [3:0]  flash_io_oe,
    input  logic [3:0]  flash_io_in
);
    logic        run, hold, rise_evt, fall_evt;
    logic        push, pop, fifo_empty, fifo_full;
    logic [15:0] push_data, head;

    assign pop = rd_stb && !addr_load && !fifo_empty;

    qsb_seq #(
        .READ_CMD    (READ_CMD),
        .DUMMY_CYCLES(DUMMY_CYCLES),
        .SAMPLE_DELAY(SAMPLE_DELAY)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (addr_load),
        .start_addr(addr_in),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .fifo_full (fifo_full),
        .io_in     (flash_io_in),
        .run       (run),
        .hold      (hold),
        .cs_n      (flash_cs_n),
        .io_out    (flash_io_out),
        .io_oe     (flash_io_oe),
        .push      (push),
        .push_data (push_data)
    );

    qsb_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .hold    (hold),
        .sck     (flash_sck),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt)
    );

    qsb_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(addr_load),
        .push (push),
        .din  (push_data),
        .pop  (pop),
        .dout (head),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    // Answer master reads from the FIFO, or flag an underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            underrun <= 1'b0;
        end else if (addr_load) begin
            underrun <= 1'b0;
        end else if (rd_stb) begin
            if (!fifo_empty) rd_data  <= head;
            else             underrun <= 1'b1;
        end
    end

    assert_restart_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> flash_cs_n);
    assert_underrun_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !addr_load && fifo_empty) |=> ($stable(rd_data) && underrun));
    assert_load_beats_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && rd_stb) |=> ($stable(rd_data) && !underrun));
endmodule

// File: tb/tb_qsb_top.sv
`timescale 1ns/1ps
// Behavioural flash: captures the header and streams nibbles after the dummy
// clocks, high nibble of each byte first. LAG models the round-trip pad delay.
module tb_flash_model #(
    parameter int  DUMMY = 8,
    parameter real LAG   = 0.0
) (
    input  logic        cs_n,
    input  logic        sck,
    input  logic [3:0]  io_from_host,
    output logic [3:0]  io_to_host,
    output logic [7:0]  cmd_seen,
    output logic [23:0] addr_seen
);
    int          rises = 0;
    int          k;
    logic [31:0] hdr = '0;
    logic [7:0]  b;
    logic [3:0]  nib;

    function automatic logic [7:0] byte_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    initial begin
        io_to_host = '0;
        cmd_seen   = '0;
        addr_seen  = '0;
    end

    always @(negedge cs_n) rises = 0;

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rises < 32) hdr = {hdr[30:0], io_from_host[0]};
            rises = rises + 1;
            if (rises == 32) begin
                cmd_seen  = hdr[31:24];
                addr_seen = hdr[23:0];
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n && rises >= 32 + DUMMY) begin
            k   = rises - (32 + DUMMY);
            b   = byte_at(addr_seen + 24'(k / 2));
            nib = (k % 2 == 0) ? b[7:4] : b[3:0];
            if (LAG > 0.0) io_to_host <= #(LAG) nib;
            else           io_to_host <= nib;
        end
    end
endmodule

// Scoreboard bench: one driver pushes expected words, a monitor compares.
module tb_qsb_top;
    localparam real CLK_PERIOD = 10.0;
    localparam int  CLK_DIV    = 2;
    localparam int  DUMMY      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [23:0] addr_in = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data, rd_data2;
    logic        underrun, underrun2;
    logic        cs_n, sck, cs_n2, sck2;
    logic [3:0]  io_out, io_oe, io_in, io_out2, io_oe2, io_in2;
    logic [7:0]  cmd1, cmd2;
    logic [23:0] adr1, adr2;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] exp_q[$];
    logic [23:0] cur_addr = '0;
    int          rd_idx = 0;
    logic        scb_on = 1'b0;
    logic        mon_pend = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    qsb_top #(.CLK_DIV(CLK_DIV), .DUMMY_CYCLES(DUMMY), .SAMPLE_DELAY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .rd_stb(rd_stb), .rd_data(rd_data), .underrun(underrun),
        .flash_cs_n(cs_n), .flash_sck(sck), .flash_io_out(io_out),
        .flash_io_oe(io_oe), .flash_io_in(io_in));

    qsb_top #(.CLK_DIV(CLK_DIV), .DUMMY_CYCLES(DUMMY), .SAMPLE_DELAY(1'b1)) dut2 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .rd_stb(rd_stb), .rd_data(rd_data2), .underrun(underrun2),
        .flash_cs_n(cs_n2), .flash_sck(sck2), .flash_io_out(io_out2),
        .flash_io_oe(io_oe2), .flash_io_in(io_in2));

    tb_flash_model #(.DUMMY(DUMMY), .LAG(0.0)) flash1 (
        .cs_n(cs_n), .sck(sck), .io_from_host(io_out), .io_to_host(io_in),
        .cmd_seen(cmd1), .addr_seen(adr1));

    tb_flash_model #(.DUMMY(DUMMY), .LAG(2.5 * CLK_PERIOD)) flash2 (
        .cs_n(cs_n2), .sck(sck2), .io_from_host(io_out2), .io_to_host(io_in2),
        .cmd_seen(cmd2), .addr_seen(adr2));

    function automatic logic [7:0] byte_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [15:0] exp_word(input logic [23:0] a, input int j);
        return {byte_at(a + 24'(2 * j)), byte_at(a + 24'(2 * j + 1))};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [23:0] a);
        @(negedge clk);
        addr_in   = a;
        addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        cur_addr  = a;
        rd_idx    = 0;
        exp_q.delete();
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_stb = 1'b1;
        scb_on = 1'b1;
        exp_q.push_back(exp_word(cur_addr, rd_idx));
        rd_idx++;
        @(negedge clk);
        rd_stb = 1'b0;
        scb_on = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: note scoreboard reads taken at each edge.
    always @(posedge clk) mon_pend <= rd_stb && scb_on;

    // Monitor: compare both bridges against the head of the queue.
    always @(negedge clk) begin
        if (mon_pend && exp_q.size() > 0) begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R3 R4 word order", 32'(rd_data), 32'(e));
            check(rd_data2 == e, "R10 late sampling", 32'(rd_data2), 32'(e));
        end
    end

    initial begin
        realtime t1, t2;
        logic [15:0] last;
        bit held;

        // R1: reset state on both instances
        wait_cycles(4);
        check(cs_n && cs_n2, "R1 cs_n", 32'({cs_n, cs_n2}), 32'h3);
        check(!sck && !sck2, "R1 sck", 32'({sck, sck2}), 32'h0);
        check(io_oe == 4'h0 && rd_data == 16'h0 && !underrun,
              "R1 oe/data/underrun", 32'({io_oe, rd_data, 3'b0, underrun}), 32'h0);
        rst_n = 1'b1;
        wait_cycles(3);

        // R6: serial clock period
        do_load(24'h000100);
        @(posedge sck) t1 = $realtime;
        @(posedge sck) t2 = $realtime;
        check((t2 - t1) == 2.0 * CLK_DIV * CLK_PERIOD, "R6 sck period",
              32'(int'(t2 - t1)), 32'(int'(2.0 * CLK_DIV * CLK_PERIOD)));
        wait_cycles(400);

        // R2: command and address as seen by the flash
        check(cmd1 == 8'h6B && cmd2 == 8'h6B, "R2 command", 32'({cmd1, cmd2}), 32'h6B6B);
        check(adr1 == 24'h000100 && adr2 == 24'h000100, "R2 address", 32'(adr1), 32'h100);

        // R5: full FIFO gates the clock while chip select stays low
        held = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck || cs_n) held = 1'b0;
        end
        check(held, "R5 gated sck, cs low", 32'({sck, cs_n}), 32'h0);

        // R3 R4: burst of reads, spaced so pushes and pops collide
        for (int i = 0; i < 12; i++) begin
            do_read();
            check(!cs_n, "R4 cs held low", 32'(cs_n), 32'h0);
            wait_cycles(18);
        end
        last = exp_word(24'h000100, 11);

        // R7: read on an empty FIFO right after a load
        do_load(24'h0A0000);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(underrun && underrun2, "R7 underrun set", 32'({underrun, underrun2}), 32'h3);
        check(rd_data == last && rd_data2 == last, "R7 last word kept", 32'(rd_data), 32'(last));
        wait_cycles(400);
        check(underrun, "R7 underrun sticky", 32'(underrun), 32'h1);
        for (int i = 0; i < 3; i++) begin
            do_read();
            wait_cycles(18);
        end

        // R8: restart in mid-burst
        do_load(24'h123456);
        check(cs_n && !underrun && !underrun2, "R8 deselect and clear",
              32'({cs_n, underrun, underrun2}), 32'h4);
        wait_cycles(400);
        check(adr1 == 24'h123456, "R8 new address", 32'(adr1), 32'h123456);
        for (int i = 0; i < 6; i++) begin
            do_read();
            wait_cycles(18);
        end
        wait_cycles(200);
        last = exp_word(24'h123456, 5);

        // R9: load and read strobe in the same cycle
        @(negedge clk);
        addr_in   = 24'h00FFFE;
        addr_load = 1'b1;
        rd_stb    = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        rd_stb    = 1'b0;
        check(rd_data == last && rd_data2 == last, "R9 read ignored", 32'(rd_data), 32'(last));
        check(!underrun && !underrun2, "R9 no underrun", 32'({underrun, underrun2}), 32'h0);
        cur_addr = 24'h00FFFE;
        rd_idx   = 0;
        exp_q.delete();
        wait_cycles(400);
        for (int i = 0; i < 3; i++) begin
            do_read();
            wait_cycles(18);
        end

        wait_cycles(5);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule